// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block sets the timing of the SCL high and low phases for an I2C master. Its inputs are the peripheral clock frequency in whole MHz, the target bus rate in kHz, a standard/fast mode select and, in fast mode, a choice between two duty shapes. From these it derives a 12-bit clock divisor, multiplies it into high and low phase lengths counted in peripheral-clock cycles, and drives `sclOut`. A 1 on `sclOut` releases the line and a 0 pulls it low. A one-cycle tick marks the start of each low phase and the start of each released phase, and a bit engine uses these ticks to place data and start/stop edges.

The released phase is counted from the first cycle in which the sampled line `sclIn` reads high. A slave that holds SCL low therefore stretches the period, and a slow rise does the same. The block also reports a rise-time allowance in peripheral-clock cycles for the selected mode. The configuration is captured on every clock while the generator is idle and is frozen while it runs. An illegal configuration raises `cfgError` and stops the generator from starting.

Top module: `i2c_scl_timer`

## Requirements
- R1: Standard mode (`fastMode`=0): divisor = floor(clkMhz*1000 / (2*rateKhz)). Released phase = divisor cycles and low phase = divisor cycles.
- R2: In standard mode a computed divisor below 4 is replaced by 4.
- R3: Fast mode with `duty169`=0: divisor = floor(clkMhz*1000 / (3*rateKhz)). Low phase = 2*divisor cycles and released phase = divisor cycles.
- R4: Fast mode with `duty169`=1: divisor = floor(clkMhz*1000 / (25*rateKhz)). Low phase = 16*divisor cycles and released phase = 9*divisor cycles.
- R5: In fast mode a computed divisor of 0 is replaced by 1.
- R6: A divisor (after clamping) above 4095 sets `cfgError`=1 with `divisor`=0 and `riseCount`=0. While the error holds, raising `enable` leaves `sclOut`=1 and produces no ticks.
- R7: A `clkMhz` value outside 2..36, or `rateKhz`=0, is an error with the same effects as R6.
- R8: `riseCount` is clkMhz+1 in standard mode and floor(clkMhz*300/1000)+1 in fast mode.
- R9: While the generator waits for the line after releasing it, `sclOut` stays 1 as long as `sclIn` reads 0. The released phase then lasts exactly its nominal length, counted from the first cycle in which `sclIn` reads 1.
- R10: In reset and while `enable`=0, `sclOut`=1. After reset `cfgError` reads 1 until the first configuration has been captured, one clock later. Dropping `enable` returns `sclOut` to 1 at the next clock edge. Enabling starts with SCL released.
- R11: Configuration inputs are captured one clock after they change, and only while the generator is idle. While it runs, changes to them have no effect on `divisor`, `riseCount` or the phase lengths.
- R12: `fallTick` is 1 for exactly the first cycle of each low phase. `riseTick` is 1 for exactly the first cycle of `sclOut`=1 after a low phase. No tick is 1 at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator |
| clkMhz | input | 6 | Peripheral clock frequency in MHz |
| rateKhz | input | 10 | Target bus rate in kHz |
| fastMode | input | 1 | 0 standard, 1 fast |
| duty169 | input | 1 | Fast mode only: 0 gives low:high 2:1, 1 gives 16:9 |
| sclIn | input | 1 | Sampled SCL line level |
| sclOut | output | 1 | 1 releases SCL, 0 pulls it low |
| riseTick | output | 1 | First cycle of a released phase after a low phase |
| fallTick | output | 1 | First cycle of a low phase |
| divisor | output | 12 | Captured divisor, 0 on error |
| riseCount | output | 6 | Rise-time allowance in clock cycles, 0 on error |
| cfgError | output | 1 | Captured configuration is illegal |

## Verification
The bench drives each clamp boundary: a standard divisor of 2 that must become 4, and fast divisors of 0 that must become 1. It checks the shortest released phase of one cycle at the 2:1 fast duty. A design that dropped a clamp, or that mis-sized the released phase when it is a single cycle, would produce the wrong phase lengths. It holds the line low past the release point. A design that started the high count at release instead of at the first high sample would shorten the released phase that follows. It also changes the configuration during a run and checks that nothing moves. Separate cases cover the overflow limit and the MHz range limit, where a faulty design would toggle SCL on an illegal configuration.

// File: rtl/sclt_pkg.sv
package sclt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SYNC = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } phase_e;

  // strobes from the phase control to the phase counter
  typedef struct packed {
    logic loadHigh;
    logic loadLow;
    logic dec;
  } cntCmd_t;

  // rate multipliers in the divisor denominator, per shape
  localparam int unsigned STD_DEN     = 2;
  localparam int unsigned FAST2_DEN   = 3;
  localparam int unsigned FAST169_DEN = 25;

  // phase multipliers per shape
  localparam int unsigned STD_HMUL     = 1;
  localparam int unsigned STD_LMUL     = 1;
  localparam int unsigned FAST2_HMUL   = 1;
  localparam int unsigned FAST2_LMUL   = 2;
  localparam int unsigned FAST169_HMUL = 9;
  localparam int unsigned FAST169_LMUL = 16;

  // fast rise allowance: 300 ns expressed per MHz
  localparam int unsigned RISE_NUM = 300;
  localparam int unsigned RISE_DEN = 1000;

endpackage

// File: rtl/sclt_cfg_calc.sv
module sclt_cfg_calc
  import sclt_pkg::*;
#(
  parameter int MHZ_W    = 6,
  parameter int RATE_W   = 10,
  parameter int DIV_W    = 12,
  parameter int CNT_W    = DIV_W + 4,
  parameter int RISE_W   = MHZ_W,
  parameter int MHZ_MIN  = 2,
  parameter int MHZ_MAX  = 36,
  parameter int STD_MIN  = 4,
  parameter int FAST_MIN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hold,
  input  logic [MHZ_W-1:0]  clkMhz,
  input  logic [RATE_W-1:0] rateKhz,
  input  logic              fastMode,
  input  logic              duty169,
  output logic              calcErr,
  output logic [DIV_W-1:0]  divQ,
  output logic [CNT_W-1:0]  hLenQ,
  output logic [CNT_W-1:0]  lLenQ,
  output logic [RISE_W-1:0] riseQ,
  output logic              errQ
);

  localparam int WK_W = 32;
  localparam logic [WK_W-1:0] DIV_MAX = WK_W'((1 << DIV_W) - 1);

  logic [WK_W-1:0] numKhz, denom, quot, minDiv, divRaw, riseFull;
  logic [WK_W-1:0] hMul, lMul, dMul;
  logic [CNT_W-1:0] hLenNext, lLenNext;
  logic rateZero, mhzBad, divOver;
  logic fastQ;

  always_comb begin
    if (!fastMode) begin
      dMul = WK_W'(STD_DEN);
      hMul = WK_W'(STD_HMUL);
      lMul = WK_W'(STD_LMUL);
    end else if (duty169) begin
      dMul = WK_W'(FAST169_DEN);
      hMul = WK_W'(FAST169_HMUL);
      lMul = WK_W'(FAST169_LMUL);
    end else begin
      dMul = WK_W'(FAST2_DEN);
      hMul = WK_W'(FAST2_HMUL);
      lMul = WK_W'(FAST2_LMUL);
    end
  end

  always_comb begin
    rateZero = (rateKhz == '0);
    mhzBad   = (WK_W'(clkMhz) < WK_W'(MHZ_MIN)) || (WK_W'(clkMhz) > WK_W'(MHZ_MAX));
    numKhz   = WK_W'(clkMhz) * WK_W'(1000);
    denom    = rateZero ? WK_W'(1) : WK_W'(rateKhz) * dMul;
    quot     = numKhz / denom;
    minDiv   = fastMode ? WK_W'(FAST_MIN) : WK_W'(STD_MIN);
    divRaw   = (quot < minDiv) ? minDiv : quot;
    divOver  = (divRaw > DIV_MAX);
    calcErr  = rateZero | mhzBad | divOver;
    riseFull = fastMode ? (WK_W'(clkMhz) * WK_W'(RISE_NUM)) / WK_W'(RISE_DEN) + WK_W'(1)
                        : WK_W'(clkMhz) + WK_W'(1);
    hLenNext = CNT_W'(divRaw[DIV_W-1:0]) * CNT_W'(hMul);
    lLenNext = CNT_W'(divRaw[DIV_W-1:0]) * CNT_W'(lMul);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ  <= '0;
      hLenQ <= '0;
      lLenQ <= '0;
      riseQ <= '0;
      errQ  <= 1'b1;
      fastQ <= 1'b0;
    end else if (!hold) begin
      fastQ <= fastMode;
      errQ  <= calcErr;
      if (calcErr) begin
        divQ  <= '0;
        hLenQ <= '0;
        lLenQ <= '0;
        riseQ <= '0;
      end else begin
        divQ  <= divRaw[DIV_W-1:0];
        hLenQ <= hLenNext;
        lLenQ <= lLenNext;
        riseQ <= RISE_W'(riseFull);
      end
    end
  end

  // R11: captured settings frozen while the generator runs
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> ($stable(divQ) && $stable(hLenQ) && $stable(lLenQ) && $stable(riseQ)));

  // R2: a valid standard-mode capture never holds a divisor under the floor
  assert_std_floor_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!errQ && !fastQ) |-> (divQ >= DIV_W'(STD_MIN)));

  // R5: a valid fast capture never holds a zero divisor
  assert_fast_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!errQ && fastQ) |-> (divQ != '0));

endmodule

// File: rtl/sclt_phase_count.sv
module sclt_phase_count
  import sclt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] hLen,
  input  logic [CNT_W-1:0] lLen,
  output logic             cntZero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.loadHigh) begin
      // the release-detect cycle already counted as the first high cycle
      cnt <= hLen - CNT_W'(2);
    end else if (cmd.loadLow) begin
      cnt <= lLen - CNT_W'(1);
    end else if (cmd.dec) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntZero = (cnt == '0);

  // R1: the phase counter never wraps below zero
  assert_cnt_no_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmd.dec |-> !cntZero);

  // R12: at most one load per cycle
  assert_one_load_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.loadHigh, cmd.loadLow, cmd.dec}));

endmodule

// File: rtl/sclt_phase_ctrl.sv
module sclt_phase_ctrl
  import sclt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    calcErr,
  input  logic    cfgErrQ,
  input  logic    hLenIsOne,
  input  logic    sclIn,
  input  logic    cntZero,
  output cntCmd_t cmd,
  output logic    running,
  output logic    sclOut,
  output logic    riseTick,
  output logic    fallTick
);

  phase_e state, stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    unique case (state)
      PH_IDLE: begin
        if (enable && !calcErr) stateNext = PH_SYNC;
      end
      PH_SYNC: begin
        if (sclIn) begin
          if (hLenIsOne) begin
            stateNext   = PH_LOW;
            cmd.loadLow = 1'b1;
          end else begin
            stateNext    = PH_HIGH;
            cmd.loadHigh = 1'b1;
          end
        end
      end
      PH_HIGH: begin
        if (cntZero) begin
          stateNext   = PH_LOW;
          cmd.loadLow = 1'b1;
        end else begin
          cmd.dec = 1'b1;
        end
      end
      PH_LOW: begin
        if (cntZero) stateNext = PH_SYNC;
        else         cmd.dec   = 1'b1;
      end
      default: stateNext = PH_IDLE;
    endcase
    if (!enable) begin
      stateNext = PH_IDLE;
      cmd       = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PH_IDLE;
      riseTick <= 1'b0;
      fallTick <= 1'b0;
    end else begin
      state    <= stateNext;
      riseTick <= (state == PH_LOW) && (stateNext == PH_SYNC);
      fallTick <= (state != PH_LOW) && (stateNext == PH_LOW);
    end
  end

  assign sclOut  = (state != PH_LOW);
  assign running = (state != PH_IDLE);

  // R6: the generator never runs on an illegal captured setting
  assert_err_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    running |-> !cfgErrQ);

  // R9: a line still held low keeps SCL released
  assert_stretch_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_SYNC && !sclIn && enable) |=> sclOut);

  // R12: ticks exclusive and aligned with the line level
  assert_tick_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseTick, fallTick}));
  assert_fall_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    fallTick |-> !sclOut);

  // R10: dropping enable releases SCL on the next edge
  assert_disable_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> sclOut);

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
  import sclt_pkg::*;
#(
  parameter int MHZ_W    = 6,
  parameter int RATE_W   = 10,
  parameter int DIV_W    = 12,
  parameter int MHZ_MIN  = 2,
  parameter int MHZ_MAX  = 36,
  parameter int STD_MIN  = 4,
  parameter int FAST_MIN = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [MHZ_W-1:0]  clkMhz,
  input  logic [RATE_W-1:0] rateKhz,
  input  logic              fastMode,
  input  logic              duty169,
  input  logic              sclIn,
  output logic              sclOut,
  output logic              riseTick,
  output logic              fallTick,
  output logic [DIV_W-1:0]  divisor,
  output logic [MHZ_W-1:0]  riseCount,
  output logic              cfgError
);

  localparam int CNT_W  = DIV_W + 4;
  localparam int RISE_W = MHZ_W;

  cntCmd_t          cmd;
  logic             running, calcErr, cntZero;
  logic [CNT_W-1:0] hLen, lLen;

  sclt_cfg_calc #(
    .MHZ_W(MHZ_W), .RATE_W(RATE_W), .DIV_W(DIV_W), .CNT_W(CNT_W),
    .RISE_W(RISE_W), .MHZ_MIN(MHZ_MIN), .MHZ_MAX(MHZ_MAX),
    .STD_MIN(STD_MIN), .FAST_MIN(FAST_MIN)
  ) uCfg (
    .clk(clk), .rstN(rstN), .hold(running),
    .clkMhz(clkMhz), .rateKhz(rateKhz), .fastMode(fastMode), .duty169(duty169),
    .calcErr(calcErr), .divQ(divisor), .hLenQ(hLen), .lLenQ(lLen),
    .riseQ(riseCount), .errQ(cfgError)
  );

  sclt_phase_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .calcErr(calcErr),
    .cfgErrQ(cfgError), .hLenIsOne(hLen == CNT_W'(1)), .sclIn(sclIn),
    .cntZero(cntZero), .cmd(cmd), .running(running), .sclOut(sclOut),
    .riseTick(riseTick), .fallTick(fallTick)
  );

  sclt_phase_count #(.CNT_W(CNT_W)) uCnt (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hLen(hLen), .lLen(lLen),
    .cntZero(cntZero)
  );

endmodule

// File: tb/tb_i2c_scl_timer.sv
module tb_i2c_scl_timer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [5:0] clkMhz = 6'd8;
  logic [9:0] rateKhz = 10'd100;
  logic fastMode = 1'b0;
  logic duty169 = 1'b0;
  logic holdLow = 1'b0;
  logic sclIn, sclOut, riseTick, fallTick, cfgError;
  logic [11:0] divisor;
  logic [5:0] riseCount;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign sclIn = sclOut & ~holdLow;

  i2c_scl_timer dut (
    .clk(clk), .rstN(rstN), .enable(enable), .clkMhz(clkMhz), .rateKhz(rateKhz),
    .fastMode(fastMode), .duty169(duty169), .sclIn(sclIn), .sclOut(sclOut),
    .riseTick(riseTick), .fallTick(fallTick), .divisor(divisor),
    .riseCount(riseCount), .cfgError(cfgError)
  );

  typedef struct packed {
    logic [5:0]  mhz;
    logic [9:0]  rate;
    logic        fast;
    logic        d169;
    logic [11:0] expDiv;
    logic        expErr;
    logic [5:0]  expRise;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{6'd8,  10'd100,  1'b0, 1'b0, 12'd40,   1'b0, 6'd9},   // R1 R8
    '{6'd36, 10'd100,  1'b0, 1'b0, 12'd180,  1'b0, 6'd37},  // R1 R8
    '{6'd2,  10'd400,  1'b0, 1'b0, 12'd4,    1'b0, 6'd3},   // R2 clamp
    '{6'd8,  10'd1,    1'b0, 1'b0, 12'd4000, 1'b0, 6'd9},   // R1 large
    '{6'd36, 10'd400,  1'b1, 1'b0, 12'd30,   1'b0, 6'd11},  // R3 R8
    '{6'd24, 10'd300,  1'b1, 1'b0, 12'd26,   1'b0, 6'd8},   // R3 R8
    '{6'd36, 10'd1000, 1'b1, 1'b0, 12'd12,   1'b0, 6'd11},  // R3
    '{6'd36, 10'd400,  1'b1, 1'b1, 12'd3,    1'b0, 6'd11},  // R4
    '{6'd2,  10'd400,  1'b1, 1'b1, 12'd1,    1'b0, 6'd1},   // R5 clamp
    '{6'd36, 10'd4,    1'b0, 1'b0, 12'd0,    1'b1, 6'd0},   // R6 overflow
    '{6'd1,  10'd100,  1'b0, 1'b0, 12'd0,    1'b1, 6'd0},   // R7 low MHz
    '{6'd37, 10'd100,  1'b0, 1'b0, 12'd0,    1'b1, 6'd0},   // R7 high MHz
    '{6'd10, 10'd0,    1'b0, 1'b0, 12'd0,    1'b1, 6'd0},   // R7 zero rate
    '{6'd36, 10'd5,    1'b0, 1'b0, 12'd3600, 1'b0, 6'd37}   // R6 edge below limit
  };

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      finishRun();
    end
  end

  task automatic setCfg(input logic [5:0] m, input logic [9:0] r, input logic f, input logic d);
    @(negedge clk);
    enable = 1'b0;
    clkMhz = m; rateKhz = r; fastMode = f; duty169 = d;
    repeat (2) @(negedge clk);
  endtask

  task automatic measure(output int lowN, output int highN);
    while (sclOut !== 1'b1) @(negedge clk);
    while (sclOut === 1'b1) @(negedge clk);
    lowN = 0;
    while (sclOut === 1'b0) begin lowN++; @(negedge clk); end
    highN = 0;
    while (sclOut === 1'b1) begin highN++; @(negedge clk); end
  endtask

  task automatic runTiming(input logic [5:0] m, input logic [9:0] r, input logic f,
                           input logic d, input int expH, input int expL, input string req);
    int lo, hi;
    setCfg(m, r, f, d);
    enable = 1'b1;
    measure(lo, hi);
    chk({req, " low phase"}, lo, expL);
    chk({req, " high phase"}, hi, expH);
  endtask

  initial begin
    int lo, hi, bad, falls, rises;
    logic prevOut;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 reset sclOut", int'(sclOut), 1);
    chk("R10 reset ticks", int'(riseTick | fallTick), 0);
    chk("R10 reset cfgError", int'(cfgError), 1);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle sclOut", int'(sclOut), 1);
    chk("R10 first capture clears error", int'(cfgError), 0);

    // configuration table: R1..R8
    for (int i = 0; i < NV; i++) begin
      setCfg(VECS[i].mhz, VECS[i].rate, VECS[i].fast, VECS[i].d169);
      chk($sformatf("R1-table divisor vec %0d", i), int'(divisor), int'(VECS[i].expDiv));
      chk($sformatf("R6 R7 error vec %0d", i), int'(cfgError), int'(VECS[i].expErr));
      chk($sformatf("R8 rise vec %0d", i), int'(riseCount), int'(VECS[i].expRise));
    end

    // phase lengths
    runTiming(6'd8,  10'd100,  1'b0, 1'b0, 40, 40, "R1");
    runTiming(6'd2,  10'd400,  1'b0, 1'b0, 4,  4,  "R2");
    runTiming(6'd36, 10'd1000, 1'b1, 1'b0, 12, 24, "R3");
    runTiming(6'd36, 10'd400,  1'b1, 1'b1, 27, 48, "R4");
    runTiming(6'd2,  10'd700,  1'b1, 1'b0, 1,  2,  "R5 2:1");
    runTiming(6'd2,  10'd400,  1'b1, 1'b1, 9,  16, "R5 16:9");

    // R9: clock stretching, divisor 4 standard
    runTiming(6'd2, 10'd400, 1'b0, 1'b0, 4, 4, "R9 baseline");
    while (sclOut !== 1'b0) @(negedge clk);
    holdLow = 1'b1;
    while (sclOut === 1'b0) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      if (sclOut !== 1'b1) bad++;
      @(negedge clk);
    end
    chk("R9 held high while stretched", bad, 0);
    holdLow = 1'b0;
    hi = 0;
    while (sclOut === 1'b1) begin hi++; @(negedge clk); end
    chk("R9 high after stretch", hi, 4);

    // R12: tick alignment over a stretch of cycles
    bad = 0; falls = 0; rises = 0;
    prevOut = sclOut;
    @(negedge clk);
    for (int k = 0; k < 60; k++) begin
      if (fallTick !== (prevOut && !sclOut)) bad++;
      if (riseTick !== (!prevOut && sclOut)) bad++;
      if (fallTick) falls++;
      if (riseTick) rises++;
      prevOut = sclOut;
      @(negedge clk);
    end
    chk("R12 tick alignment mismatches", bad, 0);
    chk("R12 fall ticks seen", int'(falls > 3), 1);
    chk("R12 rise ticks seen", int'(rises > 3), 1);

    // R11: configuration frozen while running
    clkMhz = 6'd36; rateKhz = 10'd1; fastMode = 1'b1; duty169 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 divisor frozen", int'(divisor), 4);
    chk("R11 rise frozen", int'(riseCount), 3);
    measure(lo, hi);
    chk("R11 low frozen", lo, 4);
    chk("R11 high frozen", hi, 4);

    // R10: disable during low phase
    while (sclOut !== 1'b0) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 release after disable", int'(sclOut), 1);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (sclOut !== 1'b1 || riseTick || fallTick) bad++;
      @(negedge clk);
    end
    chk("R10 stays released", bad, 0);
    // 36 MHz, 1 kHz, 16:9 -> 36000/25 = 1440, captured once idle
    chk("R11 capture after stop", int'(divisor), 1440);

    // R6 / R7: illegal settings never start
    setCfg(6'd36, 10'd4, 1'b0, 1'b0);
    enable = 1'b1;
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (sclOut !== 1'b1 || riseTick || fallTick) bad++;
    end
    chk("R6 overflow keeps idle", bad, 0);
    setCfg(6'd40, 10'd100, 1'b0, 1'b0);
    enable = 1'b1;
    bad = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (sclOut !== 1'b1 || riseTick || fallTick) bad++;
    end
    chk("R7 bad MHz keeps idle", bad, 0);

    // R10: enable starts released
    setCfg(6'd2, 10'd400, 1'b0, 1'b0);
    enable = 1'b1;
    @(negedge clk);
    chk("R10 start released", int'(sclOut), 1);
    chk("R10 no fall at start", int'(fallTick), 0);

    finishRun();
  end

endmodule